// File: doc/BRIEF.md
# Byte-Wide SPI Port with Master Demotion

This block is a full-duplex SPI port that moves one byte per transfer and works either as the bus master or as a slave. A master bit, set and cleared by one-cycle pulses, chooses the role. As master, the port times SCK from a programmable half-bit divider. Loading a byte starts the transfer at once. The port shifts the byte out MSB first on MOSI while it samples MISO, and after eight bits the clock stops. As slave, the port follows an external SCK while its active-low select is asserted. SCK and select are brought into the system clock through two flip-flops, and their edges are detected there.

At the end of every byte the port and its peer have swapped contents, as if the two shift registers formed one 16-bit ring. A sticky done flag marks the end of each byte, and an interrupt output follows that flag through an enable. If a master sees its select input driven low by another master while select-ignore is off, it demotes itself: it clears its master bit, releases SCK and MOSI, drives MISO, and raises the done flag. The pads are outside the block; it only gives output values and output enables.

Top module: `spi_port`

## Requirements
- R1: In master mode with the port enabled, an accepted `data_wr` starts a transfer with no further command. A write while a transfer runs, or while `cfg_en` is 0, is ignored.
- R2: One half bit lasts `cfg_div`+1 clocks. SCK holds its idle level `cfg_cpol` for the first half bit after the write. `done` rises exactly 16×(`cfg_div`+1) clocks after the edge that accepts the write, and SCK is back at `cfg_cpol` at that point.
- R3: A transfer is a full-duplex exchange, MSB first. Afterwards `rx_data` holds the byte the peer sent, and the peer holds the byte the port sent.
- R4: With `cfg_cpha`=0 the first bit is on the data output as soon as the byte is loaded, data is sampled on the leading SCK edge and shifted on the trailing edge. With `cfg_cpha`=1 data is driven on the leading edge and sampled on the trailing edge.
- R5: `done` is set when a byte completes or when the master is demoted. `irq` is high exactly when `done` is 1 and `irq_en` is 1.
- R6: A one-cycle `done_clr` pulse clears `done`. If a set and a clear fall in the same cycle, `done` stays 1.
- R7: If the port is enabled, in master mode, with `cfg_ssig`=0, and the synchronised `ss_n_i` is low, then within 3 clocks `mstr` is 0, `done` is 1, `sck_oe` and `mosi_oe` are 0 and `miso_oe` is 1.
- R8: After a demotion the port stays a slave, even once select is released, until `mstr_set` is pulsed. With `cfg_ssig`=1 a low select never demotes the master.
- R9: As a slave with `cfg_cpha`=0, the port exchanges a byte while `ss_n_i` is low. Releasing select resets the bit position, so the next byte after an aborted byte is received whole.
- R10: As a slave with `cfg_cpha`=1, select may stay low across several bytes, and each byte sends out the byte received before it. A `data_wr` while `ss_n_i` is low is ignored.
- R11: A master drives `sck_oe` and `mosi_oe` high and `miso_oe` low. A slave drives only `miso_oe`, and only while selected. With `cfg_en`=0 all three enables are 0.
- R12: After reset `mstr`, `done`, `irq` and all output enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Port enable |
| cfg_ssig | input | 1 | Ignore the select input |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | Clock phase |
| cfg_div | input | DIV_W | Half-bit length minus one, in clocks |
| irq_en | input | 1 | Interrupt enable |
| mstr_set | input | 1 | Pulse that sets the master bit |
| mstr_clr | input | 1 | Pulse that clears the master bit |
| data_wr | input | 1 | Load strobe for the transmit byte |
| data_wdata | input | 8 | Transmit byte |
| done_clr | input | 1 | Pulse that clears the done flag |
| mstr | output | 1 | Master bit |
| rx_data | output | 8 | Last received byte |
| done | output | 1 | Transfer-complete flag |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | SCK from the pad |
| sck_o | output | 1 | SCK to the pad |
| sck_oe | output | 1 | SCK output enable |
| mosi_i | input | 1 | MOSI from the pad |
| mosi_o | output | 1 | MOSI to the pad |
| mosi_oe | output | 1 | MOSI output enable |
| miso_i | input | 1 | MISO from the pad |
| miso_o | output | 1 | MISO to the pad |
| miso_oe | output | 1 | MISO output enable |
| ss_n_i | input | 1 | Active-low select from the pad |

## Verification
The bench counts clocks from the accepted write to the rise of `done`. A divider that is off by one, or a missing idle half bit, shifts that edge. It writes a second byte in the middle of a master transfer. A port that let that write through would corrupt the bytes the bench sees swapped. It aborts a CPHA=0 slave byte after three bits and then sends a full byte. A bit counter that did not reset on select release would finish early and give back a scrambled byte. It also times a clear pulse into the same cycle as the done set, drives select low on a master with select-ignore both off and on, and writes to a CPHA=1 slave while its select is held low. A design that got these wrong would lose the flag, fail to demote or demote wrongly, or send the written byte instead of the byte it received before.

// File: rtl/spi_port.sv
module spi_port #(
  parameter int DIV_W = 8,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_ssig,
  input  logic             cfg_cpol,
  input  logic             cfg_cpha,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             irq_en,
  input  logic             mstr_set,
  input  logic             mstr_clr,
  input  logic             data_wr,
  input  logic [7:0]       data_wdata,
  input  logic             done_clr,
  output logic             mstr,
  output logic [7:0]       rx_data,
  output logic             done,
  output logic             irq,
  input  logic             sck_i,
  output logic             sck_o,
  output logic             sck_oe,
  input  logic             mosi_i,
  output logic             mosi_o,
  output logic             mosi_oe,
  input  logic             miso_i,
  output logic             miso_o,
  output logic             miso_oe,
  input  logic             ss_n_i
);

  logic [SYNC-1:0]  sck_sy, ss_sy;
  logic             sck_s, sck_d, ss_s;
  logic             mstr_q, done_q, busy, lvl, samp, outq;
  logic [DIV_W-1:0] divcnt;
  logic [7:0]       sr, rx_q;
  logic [2:0]       bitcnt;

  assign sck_s = sck_sy[SYNC-1];
  assign ss_s  = ss_sy[SYNC-1];

  wire sel     = cfg_ssig | ~ss_s;
  wire fault   = cfg_en & mstr_q & ~cfg_ssig & ~ss_s;
  wire tick    = busy & (divcnt == cfg_div);
  wire s_edge  = cfg_en & ~mstr_q & sel & (sck_s ^ sck_d);
  wire lead    = mstr_q ? (tick & ~lvl) : (s_edge & (sck_s != cfg_cpol));
  wire trail   = mstr_q ? (tick & lvl)  : (s_edge & (sck_s == cfg_cpol));
  wire in_bit  = mstr_q ? miso_i : mosi_i;
  wire nxt_bit = cfg_cpha ? in_bit : samp;
  wire last    = trail & (bitcnt == 3'd7);
  wire wr_ok   = data_wr & cfg_en & (mstr_q ? ~busy : ss_s);
  wire out_bit = cfg_cpha ? outq : sr[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy <= '0;
      ss_sy  <= '1;
      sck_d  <= 1'b0;
    end else begin
      sck_sy <= {sck_sy[SYNC-2:0], sck_i};
      ss_sy  <= {ss_sy[SYNC-2:0], ss_n_i};
      sck_d  <= sck_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mstr_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (mstr_clr) mstr_q <= 1'b0;
      if (mstr_set) mstr_q <= 1'b1;
      if (fault)    mstr_q <= 1'b0;
      if (done_clr)     done_q <= 1'b0;
      if (last | fault) done_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      lvl    <= 1'b0;
      divcnt <= '0;
      bitcnt <= '0;
      sr     <= '0;
      rx_q   <= '0;
      samp   <= 1'b0;
      outq   <= 1'b0;
    end else if (!cfg_en || fault || mstr_clr) begin
      busy   <= 1'b0;
      lvl    <= 1'b0;
      divcnt <= '0;
      bitcnt <= '0;
    end else begin
      if (busy) divcnt <= tick ? '0 : divcnt + 1'b1;
      if (tick) lvl <= ~lvl;
      if (lead) begin
        samp <= in_bit;
        outq <= sr[7];
      end
      if (trail) begin
        sr     <= {sr[6:0], nxt_bit};
        bitcnt <= bitcnt + 3'd1;
      end
      if (last) begin
        rx_q <= {sr[6:0], nxt_bit};
        busy <= 1'b0;
      end
      if (!mstr_q && !cfg_ssig && ss_s) bitcnt <= '0;
      if (wr_ok) begin
        sr <= data_wdata;
        if (mstr_q) begin
          busy   <= 1'b1;
          lvl    <= 1'b0;
          divcnt <= '0;
          bitcnt <= '0;
        end
      end
    end
  end

  assign mstr    = mstr_q;
  assign done    = done_q;
  assign irq     = done_q & irq_en;
  assign rx_data = rx_q;
  assign sck_o   = cfg_cpol ^ lvl;
  assign sck_oe  = cfg_en & mstr_q;
  assign mosi_o  = out_bit;
  assign mosi_oe = cfg_en & mstr_q;
  assign miso_o  = out_bit;
  assign miso_oe = cfg_en & ~mstr_q & sel;

endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_en,
  input logic cfg_ssig,
  input logic cfg_cpol,
  input logic mstr,
  input logic mstr_set,
  input logic done,
  input logic done_clr,
  input logic sck_o,
  input logic sck_oe,
  input logic miso_oe,
  input logic busy,
  input logic ss_s
);

  AST_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(sck_oe && miso_oe)); // R11
  AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> sck_o == cfg_cpol); // R2
  AST_BUSY_MSTR: assert property (@(posedge clk) disable iff (!rst_n) busy |-> mstr); // R1
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) done && !done_clr |=> done); // R6
  AST_FAULT_DEMOTE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en && mstr && !cfg_ssig && !ss_s |=> !mstr && done); // R7
  AST_MSTR_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(mstr) |-> $past(mstr_set)); // R8

endmodule

bind spi_port spi_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_ssig(cfg_ssig), .cfg_cpol(cfg_cpol),
  .mstr(mstr), .mstr_set(mstr_set), .done(done), .done_clr(done_clr), .sck_o(sck_o),
  .sck_oe(sck_oe), .miso_oe(miso_oe), .busy(busy), .ss_s(ss_s)
);

// File: tb/sim_spi_port.sv
`timescale 1ns/1ps
module sim_spi_port;
  localparam int H = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_en = 0, cfg_ssig = 0, cfg_cpol = 0, cfg_cpha = 0, irq_en = 0;
  logic [7:0] cfg_div = 0;
  logic mstr_set = 0, mstr_clr = 0, data_wr = 0, done_clr = 0;
  logic [7:0] data_wdata = 0;
  logic sck_i = 0, mosi_i = 0, miso_i = 0, ss_n_i = 1;
  logic mstr, done, irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
  logic [7:0] rx_data;
  int n_chk = 0, n_bad = 0;
  logic [7:0] bsr, brx;
  logic bsamp, psck;

  always #2 clk = ~clk;

  spi_port u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk) s = 1'b1;
    @(negedge clk) s = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] b);
    @(negedge clk) begin data_wr = 1'b1; data_wdata = b; end
    @(negedge clk) data_wr = 1'b0;
  endtask

  // bench acts as slave while the port is master
  task automatic master_xfer(input logic [7:0] tx, input logic [7:0] peer, input bit mid_wr, input bit clr_end);
    int n;
    n = 16 * (int'(cfg_div) + 1);
    bsr = peer; psck = cfg_cpol; miso_i = cfg_cpha ? 1'b0 : peer[7];
    wr_byte(tx);
    chk("R2 sck idle first half", sck_o, cfg_cpol);
    if (!cfg_cpha) chk("R4 first bit on load", mosi_o, tx[7]);
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (mid_wr && k == 3) begin data_wr = 1'b1; data_wdata = 8'hFF; end
      if (mid_wr && k == 4) data_wr = 1'b0;
      if (sck_o != psck) begin
        if (sck_o != cfg_cpol) begin
          if (!cfg_cpha) bsamp = mosi_o; else miso_i = bsr[7];
        end else begin
          if (!cfg_cpha) begin bsr = {bsr[6:0], bsamp}; miso_i = bsr[7]; end
          else bsr = {bsr[6:0], mosi_o};
        end
        psck = sck_o;
      end
      if (k == n - 1) begin
        chk("R2 done not early", done, 0);
        if (clr_end) done_clr = 1'b1;
      end
      if (k == n) begin
        done_clr = 1'b0;
        chk("R2 done on time", done, 1);
        chk("R2 sck back idle", sck_o, cfg_cpol);
      end
    end
    chk("R3 port received peer byte", rx_data, peer);
    chk("R3 peer received port byte", bsr, tx);
  endtask

  // bench acts as master while the port is slave
  task automatic slave_xfer(input logic [7:0] tx, input int nbits, input bit hold);
    brx = 0;
    @(negedge clk) begin ss_n_i = 1'b0; if (!cfg_cpha) mosi_i = tx[7]; end
    repeat (H) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      if (!cfg_cpha) brx = {brx[6:0], miso_o};
      sck_i = ~cfg_cpol;
      if (cfg_cpha) mosi_i = tx[7-i];
      repeat (H) @(negedge clk);
      if (cfg_cpha) brx = {brx[6:0], miso_o};
      sck_i = cfg_cpol;
      if (!cfg_cpha && i < 7) mosi_i = tx[6-i];
      repeat (H) @(negedge clk);
    end
    if (!hold) begin
      ss_n_i = 1'b1;
      repeat (H) @(negedge clk);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R12 mstr", mstr, 0);
    chk("R12 done", done, 0);
    chk("R12 irq", irq, 0);
    chk("R12 oe", {sck_oe, mosi_oe, miso_oe}, 0);
  endtask

  task automatic t_master_cpha0;
    cfg_en = 1; cfg_cpol = 0; cfg_cpha = 0; cfg_div = 1; irq_en = 1;
    pulse(mstr_set);
    chk("R11 master oe", {sck_oe, mosi_oe, miso_oe}, 3'b110);
    master_xfer(8'hA5, 8'h3A, 1'b1, 1'b0);
    chk("R5 irq with enable", irq, 1);
    pulse(done_clr);
    chk("R6 clear", done, 0);
    chk("R5 irq follows done", irq, 0);
  endtask

  task automatic t_master_cpha1;
    cfg_cpol = 1; cfg_cpha = 1; cfg_div = 2; irq_en = 0;
    repeat (2) @(negedge clk);
    master_xfer(8'h69, 8'hD2, 1'b0, 1'b1);
    chk("R6 set wins over clear", done, 1);
    chk("R5 irq masked", irq, 0);
    pulse(done_clr);
  endtask

  task automatic t_fault;
    cfg_ssig = 1;
    @(negedge clk) ss_n_i = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 ssig keeps master", mstr, 1);
    chk("R8 ssig no done", done, 0);
    ss_n_i = 1'b1; cfg_ssig = 0;
    repeat (4) @(negedge clk);
    ss_n_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 demoted", mstr, 0);
    chk("R7 done", done, 1);
    chk("R7 oe", {sck_oe, mosi_oe, miso_oe}, 3'b001);
    ss_n_i = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 stays slave", mstr, 0);
    pulse(mstr_set);
    chk("R8 restored", mstr, 1);
    pulse(done_clr);
  endtask

  task automatic t_slave_cpha0;
    pulse(mstr_clr);
    cfg_cpol = 0; cfg_cpha = 0; sck_i = 0;
    repeat (4) @(negedge clk);
    chk("R11 slave unselected oe", {sck_oe, mosi_oe, miso_oe}, 0);
    wr_byte(8'hC3);
    slave_xfer(8'h5A, 8, 1'b0);
    chk("R9 port rx", rx_data, 8'h5A);
    chk("R9 bench rx", brx, 8'hC3);
    chk("R9 done", done, 1);
    pulse(done_clr);
    slave_xfer(8'h00, 3, 1'b0);
    chk("R9 abort no done", done, 0);
    wr_byte(8'h96);
    slave_xfer(8'h3C, 8, 1'b0);
    chk("R9 rx after abort", rx_data, 8'h3C);
    chk("R9 bench rx after abort", brx, 8'h96);
    pulse(done_clr);
  endtask

  task automatic t_slave_cpha1;
    cfg_cpol = 1; cfg_cpha = 1; sck_i = 1;
    repeat (4) @(negedge clk);
    wr_byte(8'hE1);
    slave_xfer(8'h2B, 8, 1'b1);
    chk("R10 port rx first", rx_data, 8'h2B);
    chk("R10 bench rx first", brx, 8'hE1);
    chk("R11 slave selected oe", {sck_oe, mosi_oe, miso_oe}, 3'b001);
    wr_byte(8'h77);
    slave_xfer(8'h4D, 8, 1'b1);
    chk("R10 port rx second", rx_data, 8'h4D);
    chk("R10 write blocked, ring echo", brx, 8'h2B);
    @(negedge clk) ss_n_i = 1'b1;
    pulse(done_clr);
  endtask

  task automatic t_disable;
    cfg_en = 0;
    @(negedge clk) ss_n_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 disabled oe", {sck_oe, mosi_oe, miso_oe}, 0);
    ss_n_i = 1'b1;
    pulse(mstr_set);
    wr_byte(8'h11);
    repeat (40) @(negedge clk);
    chk("R1 disabled write ignored", done, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_master_cpha0();
        t_master_cpha1();
        t_fault();
        t_slave_cpha0();
        t_slave_cpha1();
        t_disable();
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule